// File: doc/BRIEF.md
# Port Interrupt Status and Enable Unit

This unit collects the event pulses of one storage link port into a sticky status word and drives a single interrupt line. Each event source has a fixed bit position. Once a pulse arrives, that source's bit stays set until software clears it. The status word reports every latched event twice: the upper half holds the raw, unmasked value, and the lower half holds the same value ANDed with a per-source enable.

Software does not write the enables directly. One address sets enable bits and another clears them, so read-modify-write sequences are never needed. The same two addresses also hold a 2-bit steering field, which a host-level block uses to route the interrupt. The register bus is a plain single-cycle write strobe with a combinational read. The interrupt output is the OR of all masked status bits.

Top module: `port_irq_unit`

## Requirements
- R1: After reset, the status word, the enable bits, the steering field and `irq_o` are all zero.
- R2: A pulse on `evt_pulse[i]` for an implemented position i sets raw status bit 16+i on the next clock edge. The bit stays set until it is cleared. The implemented positions are 0 (command complete), 1 (error), 2 (port ready change), 3 (power change), 4 (PHY ready change), 5 (COMWAKE), 6 (unknown FIS) and 11 (SDB FIS).
- R3: Pulses on positions 7 to 10 have no effect on the status word. Enable bits at those positions cannot be set and always read zero.
- R4: Status bits [11:0] equal the raw bits [27:16] ANDed with the enable bits. Status bits [15:12] and [31:28] read zero.
- R5: A write to the enable-set address (offset 0x1010) ORs the written ones into enable bits [11:0] and steering bits [31:30]. Bits written as zero are left unchanged. A read of the enable-set address or the enable-clear address returns the enables in [11:0] and the steering in [31:30], with zero in every other bit.
- R6: A write to the enable-clear address (offset 0x1014) clears each enable or steering bit that is written as one, and leaves all other bits unchanged.
- R7: A write to the status address (offset 0x1008) clears latched event i when a one is written at bit i or at bit 16+i. Writing 0x0fff0fff clears every event.
- R8: If an event pulse arrives in the same cycle as a write that clears it, the event stays set.
- R9: `irq_o` is high exactly when at least one masked status bit is set.
- R10: Writes to any other address change nothing. Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 12 | One-cycle event pulses, one per status position |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 13 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Port interrupt, the OR of the masked status bits |

## Verification
Two functions can act on the same status bit in the same cycle: latching a new event and clearing through a status write. The bench provokes this by driving a pulse on one source together with a write of 0x0fff0fff to the status address. It then checks that this source is still set while every other source is cleared. An event-free clear of the same bit is run as a control, and there the bit must drop.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int EVT_W     = 12;
  localparam int DATA_W    = 32;
  localparam int RAW_LSB   = 16;
  localparam int STEER_W   = 2;
  localparam int STEER_LSB = DATA_W - STEER_W;
  localparam logic [EVT_W-1:0] IMPL_MASK = 12'h87F;

  // Status word: masked view in the low field, raw view shifted up.
  function automatic logic [DATA_W-1:0] pack_status(logic [EVT_W-1:0] raw,
                                                    logic [EVT_W-1:0] en);
    logic [DATA_W-1:0] w;
    w = '0;
    w[RAW_LSB +: EVT_W] = raw;
    w[EVT_W-1:0]        = raw & en;
    return w;
  endfunction

  // Enable word: enable bits low, steering field at the top.
  function automatic logic [DATA_W-1:0] pack_enable(logic [EVT_W-1:0] en,
                                                    logic [STEER_W-1:0] steer);
    logic [DATA_W-1:0] w;
    w = '0;
    w[EVT_W-1:0]             = en;
    w[STEER_LSB +: STEER_W]  = steer;
    return w;
  endfunction
endpackage

// File: rtl/port_irq_event_latch.sv
module port_irq_event_latch
  import port_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] pulse,
  input  logic [EVT_W-1:0] clr,
  output logic [EVT_W-1:0] raw_q
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= (q & ~clr[i]) | pulse[i];
      end
      assign raw_q[i] = q;

      assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse[i] |=> raw_q[i]);
      assert_clr_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !pulse[i]) |=> !raw_q[i]);
      assert_set_beats_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && pulse[i]) |=> raw_q[i]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr[i] && !pulse[i]) |=> $stable(raw_q[i]));
    end else begin : g_rsvd
      assign raw_q[i] = 1'b0;
    end
  end

  logic unused_rsvd_inputs;
  assign unused_rsvd_inputs = ^(pulse & ~IMPL_MASK) ^ ^(clr & ~IMPL_MASK);
endmodule

// File: rtl/port_irq_enable_bank.sv
module port_irq_enable_bank
  import port_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_wr,
  input  logic               clr_wr,
  input  logic [EVT_W-1:0]   en_bits,
  input  logic [STEER_W-1:0] steer_bits,
  output logic [EVT_W-1:0]   en_q,
  output logic [STEER_W-1:0] steer_q
);
  logic [EVT_W-1:0]   en_d;
  logic [STEER_W-1:0] steer_d;

  always_comb begin
    en_d    = en_q;
    steer_d = steer_q;
    if (set_wr) begin
      en_d    = en_q | (en_bits & IMPL_MASK);
      steer_d = steer_q | steer_bits;
    end else if (clr_wr) begin
      en_d    = en_q & ~en_bits;
      steer_d = steer_q & ~steer_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      steer_q <= '0;
    end else begin
      en_q    <= en_d;
      steer_q <= steer_d;
    end
  end

  assert_set_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((en_q & ($past(en_bits) & IMPL_MASK)) == ($past(en_bits) & IMPL_MASK)));
  assert_set_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((en_q & $past(en_q)) == $past(en_q)));
  assert_clr_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((en_q & $past(en_bits)) == '0) && ((steer_q & $past(steer_bits)) == '0));
  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && !clr_wr) |=> ($stable(en_q) && $stable(steer_q)));
endmodule

// File: rtl/port_irq_read_mux.sv
module port_irq_read_mux
  import port_irq_pkg::*;
(
  input  logic               hit_stat,
  input  logic               hit_en,
  input  logic [EVT_W-1:0]   raw_q,
  input  logic [EVT_W-1:0]   en_q,
  input  logic [STEER_W-1:0] steer_q,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (hit_stat)    rdata = pack_status(raw_q, en_q);
    else if (hit_en) rdata = pack_enable(en_q, steer_q);
  end
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit
  import port_irq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 13'h1008,
  parameter logic [ADDR_W-1:0] ENSET_OFS = 13'h1010,
  parameter logic [ADDR_W-1:0] ENCLR_OFS = 13'h1014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int HALF_W = DATA_W / 2;

  // Named decode events.
  logic hit_stat, hit_set, hit_clr;
  logic wr_stat, wr_set, wr_clr;
  assign hit_stat = (bus_addr == STAT_OFS);
  assign hit_set  = (bus_addr == ENSET_OFS);
  assign hit_clr  = (bus_addr == ENCLR_OFS);
  assign wr_stat  = bus_wr && hit_stat;
  assign wr_set   = bus_wr && hit_set;
  assign wr_clr   = bus_wr && hit_clr;

  // A one in either half of a status write clears the event.
  logic [HALF_W-1:0] wd_fold;
  logic [EVT_W-1:0]  stat_clr;
  assign wd_fold  = bus_wdata[HALF_W-1:0] | bus_wdata[DATA_W-1:HALF_W];
  assign stat_clr = wr_stat ? wd_fold[EVT_W-1:0] : '0;

  logic unused_fold_bits;
  assign unused_fold_bits = ^wd_fold[HALF_W-1:EVT_W];

  logic [EVT_W-1:0]   raw_q, en_q;
  logic [STEER_W-1:0] steer_q;

  port_irq_event_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .pulse (evt_pulse),
    .clr   (stat_clr),
    .raw_q (raw_q)
  );

  port_irq_enable_bank u_enable (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_wr     (wr_set),
    .clr_wr     (wr_clr),
    .en_bits    (bus_wdata[EVT_W-1:0]),
    .steer_bits (bus_wdata[STEER_LSB +: STEER_W]),
    .en_q       (en_q),
    .steer_q    (steer_q)
  );

  port_irq_read_mux u_rmux (
    .hit_stat (hit_stat),
    .hit_en   (hit_set || hit_clr),
    .raw_q    (raw_q),
    .en_q     (en_q),
    .steer_q  (steer_q),
    .rdata    (bus_rdata)
  );

  assign irq_o = |(raw_q & en_q);

  assert_irq_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (raw_q != '0) && (en_q != '0));
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata == 32'h0fff0fff && evt_pulse == '0) |=> (raw_q == '0) && !irq_o);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (raw_q == '0) && (en_q == '0) && (steer_q == '0));
endmodule

// File: tb/test_port_irq_unit.sv
`timescale 1ns/100ps
module test_port_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] evt_pulse = '0;
  logic        bus_wr = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  localparam logic [12:0] A_STAT = 13'h1008;
  localparam logic [12:0] A_SET  = 13'h1010;
  localparam logic [12:0] A_CLR  = 13'h1014;
  localparam logic [11:0] IMPL   = 12'h87F;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model state.
  logic [11:0] m_raw = '0;
  logic [11:0] m_en  = '0;
  logic [1:0]  m_st  = '0;

  always #2.5 clk = ~clk;

  port_irq_unit i_port_irq_unit (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // One clock of stimulus; model updated from the requirements.
  task automatic cyc(input logic [11:0] p, input logic wr, input logic [12:0] a, input logic [31:0] wd);
    logic [11:0] clr;
    @(negedge clk);
    evt_pulse = p; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    @(negedge clk);
    evt_pulse = '0; bus_wr = 1'b0;
    clr = (wr && a == A_STAT) ? (wd[11:0] | wd[27:16]) : 12'h0;
    m_raw = (m_raw & ~clr) | (p & IMPL);
    if (wr && a == A_SET) begin
      m_en = m_en | (wd[11:0] & IMPL);
      m_st = m_st | wd[31:30];
    end else if (wr && a == A_CLR) begin
      m_en = m_en & ~wd[11:0];
      m_st = m_st & ~wd[31:30];
    end
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    rd(A_STAT, d);
    check32(req, d, {4'h0, m_raw, 4'h0, m_raw & m_en});
    rd(A_SET, d);
    check32(req, d, {m_st, 18'h0, m_en});
    rd(A_CLR, d);
    check32(req, d, {m_st, 18'h0, m_en});
    check32({req, " irq"}, {31'h0, irq_o}, {31'h0, |(m_raw & m_en)});
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_all("R1");

    // R2 / R3 / R7: each position alone, cleared through alternating halves
    for (int i = 0; i < 12; i++) begin
      cyc(12'h1 << i, 1'b0, 13'h0, 32'h0);
      check_all(IMPL[i] ? "R2" : "R3");
      if (i % 2 == 0) cyc(12'h0, 1'b1, A_STAT, 32'h1 << i);
      else            cyc(12'h0, 1'b1, A_STAT, 32'h1 << (16 + i));
      check_all("R7");
    end

    // R3: enables at reserved positions cannot be set
    cyc(12'h0, 1'b1, A_SET, 32'h0000_0780);
    check_all("R3");

    // R4 / R5 / R6 / R9: enable sweep with all events latched
    cyc(12'hFFF, 1'b0, 13'h0, 32'h0);
    check_all("R2");
    for (int k = 0; k < 24; k++) begin
      logic [11:0] pat;
      pat = 12'((k * 12'h9D3) ^ (k << 5));
      cyc(12'h0, 1'b1, A_SET, {2'(k), 18'h0, pat});
      check_all("R5");
      check_all("R4");
      cyc(12'h0, 1'b1, A_CLR, {2'(k + 1), 18'h0, 12'(pat ^ (k * 7))});
      check_all("R6");
      check_all("R9");
    end

    // R9: single enabled event, then its removal drops irq
    cyc(12'h0, 1'b1, A_CLR, 32'hFFFF_FFFF);
    cyc(12'h0, 1'b1, A_STAT, 32'h0fff0fff);
    cyc(12'h0, 1'b1, A_SET, 32'h0000_0800);
    check_all("R9");
    cyc(12'h800, 1'b0, 13'h0, 32'h0);
    check_all("R9");
    check32("R9 irq high", {31'h0, irq_o}, 32'h1);
    cyc(12'h0, 1'b1, A_STAT, 32'h0800_0000);
    check_all("R9");
    check32("R9 irq low", {31'h0, irq_o}, 32'h0);

    // R5 / R6 steering set then partial clear
    cyc(12'h0, 1'b1, A_SET, 32'hC000_0000);
    check_all("R5");
    cyc(12'h0, 1'b1, A_CLR, 32'h4000_0000);
    check_all("R6");

    // R8: pulse on bit 0 together with a clear-all; bit 0 stays, others go
    cyc(12'h87F, 1'b0, 13'h0, 32'h0);
    cyc(12'h001, 1'b1, A_STAT, 32'h0fff0fff);
    check_all("R8");
    rd(A_STAT, d);
    check32("R8 raw", d & 32'h0FFF_0000, 32'h0001_0000);
    // control: clear without pulse drops it
    cyc(12'h0, 1'b1, A_STAT, 32'h0000_0001);
    check_all("R8");
    check32("R7 clear", m_raw, 12'h0);

    // R10: other addresses ignored, read as zero
    cyc(12'h0, 1'b1, A_SET, 32'h0000_0013);
    cyc(12'h013, 1'b0, 13'h0, 32'h0);
    cyc(12'h0, 1'b1, 13'h1000, 32'hFFFF_FFFF);
    cyc(12'h0, 1'b1, 13'h100C, 32'hFFFF_FFFF);
    cyc(12'h0, 1'b1, 13'h1018, 32'hFFFF_FFFF);
    check_all("R10");
    rd(13'h1000, d);
    check32("R10 unmapped", d, 32'h0);
    rd(13'h100C, d);
    check32("R10 unmapped", d, 32'h0);

    // R7 clear-all with nothing pending afterward
    cyc(12'h0, 1'b1, A_STAT, 32'h0fff0fff);
    check_all("R7");

    // R1 again after a mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_raw = '0; m_en = '0; m_st = '0;
    check_all("R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule